// File: doc/BRIEF.md
# Address-Space-Tagged Translation Lookaside Buffer

This block caches virtual-to-physical page translations in a fully associative array. Every slot holds a virtual page tag, a physical page number, an address space number, a global flag that makes the slot visible to every address space, per-privilege-mode read and write enable masks, and fault-on-read / fault-on-write flags. A combinational lookup compares the presented page number and current address space number against all slots at once. It returns a hit flag, the index of the matching slot and that slot's fields.

New translations are written through an insert port. The slot to write is chosen by a single rotating replacement pointer, and any entry already in that slot is overwritten. Three invalidate commands maintain the array: clear everything, drop every entry that belongs to a particular process (all non-global ones), and drop the entries that would match one page number in one address space. Pages are 8 KB, so the tag is the virtual address with its 13 low-order offset bits removed.

Top module: `asn_tlb`

## Requirements
- R1: After reset no slot is valid, every lookup misses, and the replacement pointer is at slot 0.
- R2: A lookup hits only on a valid slot whose tag equals `lk_vpn` and whose global flag is set or whose stored address space number equals `lk_asn`. On a hit, the outputs carry that slot's index, physical page, global flag, read/write masks and fault flags. On a miss, all field outputs are zero.
- R3: When several slots match, the lowest slot index is reported.
- R4: An insert writes the slot named by the replacement pointer, replacing any valid entry there. The tag is `ins_va` bits [42:13], and the low 13 bits are ignored. The pointer then advances by one and wraps from the last slot to slot 0.
- R5: Flush-all invalidates every slot and returns the replacement pointer to slot 0.
- R6: Flush-process invalidates every slot whose global flag is clear and leaves global slots valid.
- R7: Flush-address invalidates every slot that a lookup of (`fl_vpn`, `fl_asn`) would hit, using the global rule of R2, and leaves all other slots untouched.
- R8: An insert presented in the same cycle as any flush is applied after the flush. The inserted entry stays valid, and when the flush is flush-all, the insert lands in slot 0 and the pointer moves to slot 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lk_vpn | input | 30 | Lookup virtual page number |
| lk_asn | input | 8 | Current address space number |
| lk_hit | output | 1 | Lookup matched a slot |
| lk_idx | output | $clog2(ENTRIES) | Index of the reported slot |
| lk_ppn | output | 27 | Physical page number of the reported slot |
| lk_global | output | 1 | Global flag of the reported slot |
| lk_rd_en | output | 4 | Per-mode read enables of the reported slot |
| lk_wr_en | output | 4 | Per-mode write enables of the reported slot |
| lk_flt_rd | output | 1 | Fault-on-read flag of the reported slot |
| lk_flt_wr | output | 1 | Fault-on-write flag of the reported slot |
| ins_valid | input | 1 | Insert strobe |
| ins_va | input | 43 | Virtual address of the new translation |
| ins_ppn | input | 27 | Physical page number to store |
| ins_asn | input | 8 | Address space number to store |
| ins_global | input | 1 | Global flag to store |
| ins_rd_en | input | 4 | Read enable mask to store |
| ins_wr_en | input | 4 | Write enable mask to store |
| ins_flt_rd | input | 1 | Fault-on-read flag to store |
| ins_flt_wr | input | 1 | Fault-on-write flag to store |
| fl_all | input | 1 | Invalidate every slot |
| fl_proc | input | 1 | Invalidate all non-global slots |
| fl_addr | input | 1 | Invalidate slots matching fl_vpn / fl_asn |
| fl_vpn | input | 30 | Page number for flush-address |
| fl_asn | input | 8 | Address space number for flush-address |

## Verification
An insert and an invalidate can land on the same clock edge. This is the case where the ordering matters. The bench provokes it three ways: a non-global insert together with flush-process, an insert together with flush-all, and an insert together with a flush-address that names the very translation being inserted. Each case is judged at the lookup port. The new page must hit at the expected slot, while the entries the flush was aimed at must miss. For flush-all, the following insert must land in slot 1, which shows the pointer restarted at slot 0 before it advanced.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int VA_W       = 43;
  localparam int PAGE_SHIFT = 13;
  localparam int VPN_W      = VA_W - PAGE_SHIFT;
  localparam int PPN_W      = 27;
  localparam int ASN_W      = 8;
  localparam int MODES      = 4;

  typedef struct packed {
    logic             valid;
    logic [VPN_W-1:0] tag;
    logic [PPN_W-1:0] ppn;
    logic [ASN_W-1:0] asn;
    logic             glob;
    logic [MODES-1:0] rd_en;
    logic [MODES-1:0] wr_en;
    logic             flt_rd;
    logic             flt_wr;
  } tlb_entry_t;

  // page number of a virtual address: offset bits dropped
  function automatic logic [VPN_W-1:0] va_to_vpn(input logic [VA_W-1:0] va);
    return va[VA_W-1:PAGE_SHIFT];
  endfunction

  // hit rule shared by lookup and flush-address
  function automatic logic entry_hits(input tlb_entry_t e,
                                      input logic [VPN_W-1:0] vpn,
                                      input logic [ASN_W-1:0] asn);
    return e.valid && (e.tag == vpn) && (e.glob || (e.asn == asn));
  endfunction

  // rotating pointer step with wrap to zero
  function automatic int unsigned ptr_step(input int unsigned p, input int unsigned n);
    return (p + 1 >= n) ? 0 : p + 1;
  endfunction
endpackage

// File: rtl/tlb_match.sv
module tlb_match
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 48
) (
  input  tlb_entry_t         ents [ENTRIES],
  input  logic [VPN_W-1:0]   vpn,
  input  logic [ASN_W-1:0]   asn,
  output logic [ENTRIES-1:0] hit_vec
);
  for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
    assign hit_vec[i] = entry_hits(ents[i], vpn, asn);
  end
endmodule

// File: rtl/tlb_first_set.sv
module tlb_first_set #(
  parameter int N  = 48,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  req,
  output logic          found,
  output logic [IW-1:0] idx
);
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IW'(i);
    end
  end
  assign found = |req;
endmodule

// File: rtl/tlb_nlu_ptr.sv
module tlb_nlu_ptr
  import tlb_pkg::*;
#(
  parameter int N  = 48,
  parameter int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  input  logic          advance,
  output logic [IW-1:0] ptr,
  output logic [IW-1:0] slot
);
  // a restart in the same cycle wins before the advance is applied
  assign slot = restart ? '0 : ptr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ptr <= '0;
    else if (advance) ptr <= IW'(ptr_step(int'(slot), N));
    else              ptr <= slot;
  end
endmodule

// File: rtl/asn_tlb.sv
module asn_tlb
  import tlb_pkg::*;
#(
  parameter  int ENTRIES = 48,
  localparam int IDX_W   = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [VPN_W-1:0] lk_vpn,
  input  logic [ASN_W-1:0] lk_asn,
  output logic             lk_hit,
  output logic [IDX_W-1:0] lk_idx,
  output logic [PPN_W-1:0] lk_ppn,
  output logic             lk_global,
  output logic [MODES-1:0] lk_rd_en,
  output logic [MODES-1:0] lk_wr_en,
  output logic             lk_flt_rd,
  output logic             lk_flt_wr,
  input  logic             ins_valid,
  input  logic [VA_W-1:0]  ins_va,
  input  logic [PPN_W-1:0] ins_ppn,
  input  logic [ASN_W-1:0] ins_asn,
  input  logic             ins_global,
  input  logic [MODES-1:0] ins_rd_en,
  input  logic [MODES-1:0] ins_wr_en,
  input  logic             ins_flt_rd,
  input  logic             ins_flt_wr,
  input  logic             fl_all,
  input  logic             fl_proc,
  input  logic             fl_addr,
  input  logic [VPN_W-1:0] fl_vpn,
  input  logic [ASN_W-1:0] fl_asn
);
  tlb_entry_t         ents [ENTRIES];
  tlb_entry_t         new_entry;
  tlb_entry_t         sel;
  logic [ENTRIES-1:0] lk_match_vec;
  logic [ENTRIES-1:0] fa_match_vec;
  logic [ENTRIES-1:0] kill_vec;
  logic [ENTRIES-1:0] wr_sel_vec;
  logic [ENTRIES-1:0] valid_vec;
  logic [ENTRIES-1:0] glob_vec;
  logic [IDX_W-1:0]   nlu_ptr;
  logic [IDX_W-1:0]   wr_slot;
  logic               found;

  // lookup compare and flush-address compare share one rule
  tlb_match #(.ENTRIES(ENTRIES)) u_lk_match (
    .ents(ents), .vpn(lk_vpn), .asn(lk_asn), .hit_vec(lk_match_vec)
  );

  tlb_match #(.ENTRIES(ENTRIES)) u_fa_match (
    .ents(ents), .vpn(fl_vpn), .asn(fl_asn), .hit_vec(fa_match_vec)
  );

  tlb_first_set #(.N(ENTRIES), .IW(IDX_W)) u_prio (
    .req(lk_match_vec), .found(found), .idx(lk_idx)
  );

  tlb_nlu_ptr #(.N(ENTRIES), .IW(IDX_W)) u_ptr (
    .clk(clk), .rst_n(rst_n), .restart(fl_all), .advance(ins_valid),
    .ptr(nlu_ptr), .slot(wr_slot)
  );

  always_comb begin
    new_entry        = '0;
    new_entry.valid  = 1'b1;
    new_entry.tag    = va_to_vpn(ins_va);
    new_entry.ppn    = ins_ppn;
    new_entry.asn    = ins_asn;
    new_entry.glob   = ins_global;
    new_entry.rd_en  = ins_rd_en;
    new_entry.wr_en  = ins_wr_en;
    new_entry.flt_rd = ins_flt_rd;
    new_entry.flt_wr = ins_flt_wr;
  end

  for (genvar i = 0; i < ENTRIES; i++) begin : g_slot
    assign valid_vec[i]  = ents[i].valid;
    assign glob_vec[i]   = ents[i].glob;
    assign kill_vec[i]   = fl_all | (fl_proc & ~ents[i].glob) | (fl_addr & fa_match_vec[i]);
    assign wr_sel_vec[i] = ins_valid & (wr_slot == IDX_W'(i));

    // insert overrides a same-cycle invalidate of the written slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             ents[i] <= '0;
      else if (wr_sel_vec[i]) ents[i] <= new_entry;
      else if (kill_vec[i])   ents[i].valid <= 1'b0;
    end
  end

  assign sel       = found ? ents[lk_idx] : '0;
  assign lk_hit    = found;
  assign lk_ppn    = sel.ppn;
  assign lk_global = sel.glob;
  assign lk_rd_en  = sel.rd_en;
  assign lk_wr_en  = sel.wr_en;
  assign lk_flt_rd = sel.flt_rd;
  assign lk_flt_wr = sel.flt_wr;
endmodule

// File: rtl/tlb_chk.sv
module tlb_chk
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 48,
  parameter int IW      = $clog2(ENTRIES)
) (
  input logic               clk,
  input logic               rst_n,
  input logic               ins_valid,
  input logic               fl_all,
  input logic               fl_proc,
  input logic               fl_addr,
  input logic               lk_hit,
  input logic [IW-1:0]      lk_idx,
  input logic [IW-1:0]      ptr,
  input logic [IW-1:0]      slot,
  input logic [ENTRIES-1:0] match_vec,
  input logic [ENTRIES-1:0] valid_vec,
  input logic [ENTRIES-1:0] glob_vec
);
  logic [ENTRIES-1:0] below_mask;
  logic               idle;
  assign below_mask = (ENTRIES'(1) << lk_idx) - ENTRIES'(1);
  assign idle       = !ins_valid && !fl_all && !fl_proc && !fl_addr;

  p_reset_empty_r1: assert property (@(posedge clk)
    !rst_n |=> (valid_vec == '0) && (ptr == '0));

  p_miss_none_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_hit |-> (match_vec == '0));

  p_lowest_r3: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> match_vec[lk_idx] && ((match_vec & below_mask) == '0));

  p_ptr_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_valid && !fl_all) |=> (ptr == IW'(ptr_step(int'($past(ptr)), ENTRIES))));

  p_flush_all_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_all && !ins_valid) |=> (valid_vec == '0) && (ptr == '0));

  p_proc_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_proc && !fl_all && !fl_addr && !ins_valid) |=>
      (valid_vec == $past(valid_vec & glob_vec)));

  // with no command no slot may change state (R7: only targeted slots drop)
  p_idle_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    idle |=> $stable(valid_vec));

  p_ins_survives_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ins_valid |=> valid_vec[$past(slot)]);
endmodule

bind asn_tlb tlb_chk #(.ENTRIES(ENTRIES), .IW(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ins_valid(ins_valid), .fl_all(fl_all),
  .fl_proc(fl_proc), .fl_addr(fl_addr), .lk_hit(lk_hit), .lk_idx(lk_idx),
  .ptr(nlu_ptr), .slot(wr_slot), .match_vec(lk_match_vec),
  .valid_vec(valid_vec), .glob_vec(glob_vec)
);

// File: tb/tb_asn_tlb.sv
module tb_asn_tlb;
  import tlb_pkg::*;
  localparam int N  = 8;
  localparam int IW = $clog2(N);
  localparam int NV = 7;
  // vector: [31:24] vpn, [23:20] asn, [16] hit, [15:12] idx, [11:0] ppn
  localparam logic [31:0] VEC [NV] = '{
    32'h1011_0100, 32'h1031_2102, 32'h1020_0000, 32'h1171_1101,
    32'h1211_3103, 32'h1261_4104, 32'h1310_0000
  };

  logic clk = 0, rst_n = 0;
  logic [VPN_W-1:0] lk_vpn = '0, fl_vpn = '0;
  logic [ASN_W-1:0] lk_asn = '0, fl_asn = '0, ins_asn = '0;
  logic lk_hit, lk_global, lk_flt_rd, lk_flt_wr;
  logic [IW-1:0] lk_idx;
  logic [PPN_W-1:0] lk_ppn, ins_ppn = '0;
  logic [MODES-1:0] lk_rd_en, lk_wr_en, ins_rd_en = '0, ins_wr_en = '0;
  logic ins_valid = 0, ins_global = 0, ins_flt_rd = 0, ins_flt_wr = 0;
  logic [VA_W-1:0] ins_va = '0;
  logic fl_all = 0, fl_proc = 0, fl_addr = 0;
  int n_chk = 0, n_err = 0;
  bit done = 0;

  always #4 clk = ~clk;

  asn_tlb #(.ENTRIES(N)) dut (
    .clk(clk), .rst_n(rst_n), .lk_vpn(lk_vpn), .lk_asn(lk_asn), .lk_hit(lk_hit),
    .lk_idx(lk_idx), .lk_ppn(lk_ppn), .lk_global(lk_global), .lk_rd_en(lk_rd_en),
    .lk_wr_en(lk_wr_en), .lk_flt_rd(lk_flt_rd), .lk_flt_wr(lk_flt_wr),
    .ins_valid(ins_valid), .ins_va(ins_va), .ins_ppn(ins_ppn), .ins_asn(ins_asn),
    .ins_global(ins_global), .ins_rd_en(ins_rd_en), .ins_wr_en(ins_wr_en),
    .ins_flt_rd(ins_flt_rd), .ins_flt_wr(ins_flt_wr), .fl_all(fl_all),
    .fl_proc(fl_proc), .fl_addr(fl_addr), .fl_vpn(fl_vpn), .fl_asn(fl_asn)
  );

  task automatic check(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic probe(input string req, input int vpn, input int asn,
                       input bit ehit, input int eidx, input int eppn);
    @(negedge clk);
    lk_vpn = VPN_W'(vpn);
    lk_asn = ASN_W'(asn);
    #1;
    check(req, "hit", 64'(lk_hit), 64'(ehit));
    if (ehit) begin
      check(req, "idx", 64'(lk_idx), 64'(eidx));
      check(req, "ppn", 64'(lk_ppn), 64'(eppn));
    end else begin
      check(req, "ppn on miss", 64'(lk_ppn), 64'd0);
    end
  endtask

  // one clock of commands; insert fields derive from glob so the bench knows them
  task automatic op(input bit ins, input bit fa, input bit fp, input bit fd,
                    input int vpn, input int asn, input bit glob, input int ppn,
                    input int fvpn, input int fasn);
    @(negedge clk);
    ins_valid  = ins;
    ins_va     = {VPN_W'(vpn), 13'h1abc};
    ins_asn    = ASN_W'(asn);
    ins_global = glob;
    ins_ppn    = PPN_W'(ppn);
    ins_rd_en  = glob ? 4'b0011 : 4'b1111;
    ins_wr_en  = 4'b0001;
    ins_flt_rd = glob;
    ins_flt_wr = ~glob;
    fl_all = fa; fl_proc = fp; fl_addr = fd;
    fl_vpn = VPN_W'(fvpn); fl_asn = ASN_W'(fasn);
    @(posedge clk);
    #1;
    ins_valid = 0; fl_all = 0; fl_proc = 0; fl_addr = 0;
  endtask

  task automatic insert(input int vpn, input int asn, input bit glob, input int ppn);
    op(1, 0, 0, 0, vpn, asn, glob, ppn, 0, 0);
  endtask

  initial begin
    #(8 * 200000);
    n_err++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R1: empty after reset
    probe("R1", 'h10, 1, 0, 0, 0);
    probe("R1", 0, 0, 0, 0, 0);

    insert('h10, 1, 0, 'h100);
    insert('h11, 2, 1, 'h101);
    insert('h10, 3, 0, 'h102);
    insert('h12, 1, 0, 'h103);
    insert('h12, 5, 1, 'h104);

    // R2 / R3 / R4: vector table (index 4 is the double-match case of R3)
    for (int k = 0; k < NV; k++) begin
      probe((k == 4) ? "R3" : "R2", int'(VEC[k][31:24]), int'(VEC[k][23:20]),
            VEC[k][16], int'(VEC[k][15:12]), int'(VEC[k][11:0]));
    end

    // R2: field outputs of a global and a non-global slot
    probe("R2", 'h11, 0, 1, 1, 'h101);
    check("R2", "global", 64'(lk_global), 64'd1);
    check("R2", "rd_en", 64'(lk_rd_en), 64'h3);
    check("R2", "flt_rd", 64'(lk_flt_rd), 64'd1);
    check("R2", "flt_wr", 64'(lk_flt_wr), 64'd0);
    probe("R2", 'h10, 1, 1, 0, 'h100);
    check("R2", "rd_en", 64'(lk_rd_en), 64'hf);
    check("R2", "wr_en", 64'(lk_wr_en), 64'h1);
    check("R2", "flt_wr", 64'(lk_flt_wr), 64'd1);

    // R7: flush one address; same page in another space survives
    op(0, 0, 0, 1, 0, 0, 0, 0, 'h10, 1);
    probe("R7", 'h10, 1, 0, 0, 0);
    probe("R7", 'h10, 3, 1, 2, 'h102);
    probe("R7", 'h11, 2, 1, 1, 'h101);
    // R7: global slot 4 is removed by the flush of asn 1 too
    op(0, 0, 0, 1, 0, 0, 0, 0, 'h12, 1);
    probe("R7", 'h12, 1, 0, 0, 0);
    probe("R7", 'h12, 5, 0, 0, 0);

    // R6: process flush keeps only global slots
    op(0, 0, 1, 0, 0, 0, 0, 0, 0, 0);
    probe("R6", 'h10, 3, 0, 0, 0);
    probe("R6", 'h11, 9, 1, 1, 'h101);

    // R4: fill slots 5..7, then wrap to slot 0 and replace slot 1
    insert('h15, 1, 0, 'h105);
    insert('h16, 1, 0, 'h106);
    insert('h17, 1, 0, 'h107);
    probe("R4", 'h17, 1, 1, 7, 'h107);
    insert('h20, 1, 0, 'h200);
    probe("R4", 'h20, 1, 1, 0, 'h200);
    insert('h21, 1, 0, 'h201);
    probe("R4", 'h21, 1, 1, 1, 'h201);
    probe("R4", 'h11, 2, 0, 0, 0);

    // R8: process flush with a non-global insert in the same cycle
    op(1, 0, 1, 0, 'h30, 1, 0, 'h300, 0, 0);
    probe("R8", 'h30, 1, 1, 2, 'h300);
    probe("R8", 'h20, 1, 0, 0, 0);
    // R8: flush-all with insert lands in slot 0, next insert in slot 1
    op(1, 1, 0, 0, 'h40, 1, 0, 'h400, 0, 0);
    probe("R8", 'h40, 1, 1, 0, 'h400);
    probe("R8", 'h30, 1, 0, 0, 0);
    insert('h41, 1, 0, 'h401);
    probe("R8", 'h41, 1, 1, 1, 'h401);
    // R8: flush-address of the page being inserted keeps the new copy
    op(1, 0, 0, 1, 'h41, 1, 0, 'h777, 'h41, 1);
    probe("R8", 'h41, 1, 1, 2, 'h777);

    // R5: flush-all alone empties the array and restarts the pointer
    op(0, 1, 0, 0, 0, 0, 0, 0, 0, 0);
    probe("R5", 'h40, 1, 0, 0, 0);
    probe("R5", 'h41, 1, 0, 0, 0);
    insert('h50, 2, 0, 'h500);
    probe("R5", 'h50, 2, 1, 0, 'h500);

    // R1: asynchronous reset in mid-run empties the array again
    @(negedge clk);
    rst_n = 0;
    @(negedge clk);
    rst_n = 1;
    probe("R1", 'h50, 2, 0, 0, 0);
    insert('h51, 2, 0, 'h510);
    probe("R1", 'h51, 2, 1, 0, 'h510);

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule